// File: doc/BRIEF.md
# Write-Verify Conductance Programming Controller

This controller steers one analogue memory cell toward a target conductance code. It alternates identical programming pulses with read-backs of the cell. The direction is chosen once, from a read taken before any pulse. If the cell reads below the goal, the controller issues conductance-raising (SET) pulses. If it reads above the goal, it issues conductance-lowering (RESET) pulses. It stops as soon as a reading reaches or crosses the goal. It reports failure when the budget of pulses for the chosen direction runs out first.

A sequencer pulses `start` with a goal code on `target`. The controller then raises `rd_req` whenever it needs a reading. The analogue sense path answers with `rd_code` qualified by `rd_valid`, after any number of cycles. `set_pulse` and `reset_pulse` are level requests that last exactly one pulse width. The external driver turns them into bit-line or source-line pulses, with the other line grounded. When the job ends, `done` strobes for one cycle. The verdict, the pulse count and the last reading stay on their outputs until the next start.

Top module: `wv_prog_ctrl`

## Requirements
- R1: While reset is held, and after it is released, `set_pulse`, `reset_pulse`, `rd_req`, `done`, `pass` and `pulse_cnt` are all 0.
- R2: After `start` the controller raises `rd_req` before issuing any pulse. If that first reading equals the target, `done` rises with `pass`=1 and `pulse_cnt`=0, and no pulse is issued.
- R3: If the first reading is below the target, only `set_pulse` pulses are issued. The run ends with `pass`=1 at the first reading that is greater than or equal to the target.
- R4: If the first reading is above the target, only `reset_pulse` pulses are issued. The run ends with `pass`=1 at the first reading that is less than or equal to the target.
- R5: Each pulse request stays high for exactly PULSE_CYC cycles. `rd_req` is never high during a pulse. A read-back completes between any two pulses.
- R6: In the raising direction, if SET_LIMIT pulses have not reached the target, the run ends with `pass`=0 and `pulse_cnt`=SET_LIMIT.
- R7: In the lowering direction, if RESET_LIMIT pulses have not reached the target, the run ends with `pass`=0 and `pulse_cnt`=RESET_LIMIT.
- R8: A pulse that overshoots the target ends the run with `pass`=1. No pulse of the opposite direction is ever issued within a run.
- R9: `final_code` equals the last accepted reading. `pulse_cnt` equals the number of pulses issued. Both, and `pass`, hold their values after `done` until the next start.
- R10: A `start` pulse, or a change of `target`, while a run is in progress has no effect on that run's pulses, verdict or count.
- R11: `done` is high for exactly one cycle per run, and `set_pulse` and `reset_pulse` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a programming run (accepted only when idle) |
| target | input | CODE_W | Goal conductance code, captured at start |
| rd_code | input | CODE_W | Cell reading from the sense path |
| rd_valid | input | 1 | `rd_code` is valid this cycle |
| set_pulse | output | 1 | Request for a conductance-raising pulse (bit line driven) |
| reset_pulse | output | 1 | Request for a conductance-lowering pulse (source line driven) |
| rd_req | output | 1 | A reading is wanted; held until `rd_valid` |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | The target was reached |
| pulse_cnt | output | CNT_W | Pulses issued in the last run |
| final_code | output | CODE_W | Last reading accepted |

## Verification
The hardest cases to reach are the failures at the pulse limit and the overshoot crossing. Both depend on how the cell responds, not on anything the controller's inputs set directly. The bench therefore models the cell as a saturating code that moves by a fixed step on each pulse. It sweeps every start code against every target for steps of zero, one and three. A step of zero forces both limit failures, and a step of three forces overshoot. Read latency varies from run to run. On some runs the bench fires a stray start and flips the target in the middle of a pulse.

// File: rtl/wv_pkg.sv
package wv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_PULSE = 2'd2,
      ST_DONE  = 2'd3
   } wv_state_e;

   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } wv_dir_e;

   function automatic int wv_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/wv_verdict.sv
module wv_verdict
   import wv_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic [CODE_W-1:0] reading,
   input  logic [CODE_W-1:0] goal,
   input  wv_dir_e           dir,
   output logic              same,
   output logic              below,
   output logic              reached
);

   if (CODE_W < 1) begin : g_bad_width
      $error("wv_verdict: CODE_W must be at least 1");
   end

   always_comb begin
      same    = (reading == goal);
      below   = (reading < goal);
      reached = (dir == DIR_UP) ? (reading >= goal) : (reading <= goal);
   end

endmodule

// File: rtl/wv_pulse_timer.sv
module wv_pulse_timer #(
   parameter int PULSE_CYC = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic active,
   output logic last
);

   if (PULSE_CYC < 1) begin : g_bad_len
      $error("wv_pulse_timer: PULSE_CYC must be at least 1");
   end

   if (PULSE_CYC == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) active <= 1'b0;
         else        active <= fire;
      end
      assign last = active;
   end else begin : g_count
      localparam int TW = $clog2(PULSE_CYC);
      localparam logic [TW-1:0] LAST_V = TW'(PULSE_CYC - 1);
      logic [TW-1:0] tcnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            active <= 1'b0;
            tcnt   <= '0;
         end else if (fire) begin
            active <= 1'b1;
            tcnt   <= '0;
         end else if (active) begin
            if (tcnt == LAST_V) active <= 1'b0;
            else                tcnt   <= tcnt + 1'b1;
         end
      end
      assign last = active && (tcnt == LAST_V);

      AST_TMR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         active |-> (tcnt <= LAST_V)); // R5
   end

   AST_TMR_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> !active); // R5
   AST_TMR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> !active); // R5

endmodule

// File: rtl/wv_pulse_tally.sv
module wv_pulse_tally
   import wv_pkg::*;
#(
   parameter int SET_LIMIT   = 300,
   parameter int RESET_LIMIT = 500,
   parameter int CNT_W       = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             bump,
   input  wv_dir_e          dir,
   output logic [CNT_W-1:0] count,
   output logic             at_limit
);

   localparam logic [CNT_W-1:0] UP_CAP   = CNT_W'(SET_LIMIT);
   localparam logic [CNT_W-1:0] DOWN_CAP = CNT_W'(RESET_LIMIT);

   if (SET_LIMIT < 1 || RESET_LIMIT < 1) begin : g_bad_limit
      $error("wv_pulse_tally: limits must be at least 1");
   end
   if (CNT_W < $clog2(wv_max(SET_LIMIT, RESET_LIMIT) + 1)) begin : g_bad_cnt
      $error("wv_pulse_tally: CNT_W too narrow for the limits");
   end

   logic [CNT_W-1:0] cap;
   assign cap      = (dir == DIR_UP) ? UP_CAP : DOWN_CAP;
   assign at_limit = (count == cap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (clear) count <= '0;
      else if (bump)  count <= count + 1'b1;
   end

   AST_TALLY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      bump |-> !at_limit); // R6
   AST_TALLY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !clear && !bump |=> (count <= DOWN_CAP || count <= UP_CAP)); // R7

endmodule

// File: rtl/wv_prog_ctrl.sv
module wv_prog_ctrl
   import wv_pkg::*;
#(
   parameter  int CODE_W      = 8,
   parameter  int PULSE_CYC   = 7,
   parameter  int SET_LIMIT   = 300,
   parameter  int RESET_LIMIT = 500,
   localparam int CNT_W       = $clog2(wv_max(SET_LIMIT, RESET_LIMIT) + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CODE_W-1:0] target,
   input  logic [CODE_W-1:0] rd_code,
   input  logic              rd_valid,
   output logic              set_pulse,
   output logic              reset_pulse,
   output logic              rd_req,
   output logic              done,
   output logic              pass,
   output logic [CNT_W-1:0]  pulse_cnt,
   output logic [CODE_W-1:0] final_code
);

   wv_state_e         state;
   wv_dir_e           dir_q;
   logic [CODE_W-1:0] tgt_q;
   logic              first_q;
   logic              pass_q;
   logic [CODE_W-1:0] final_q;

   logic same, below, reached;
   logic tmr_active, tmr_last;
   logic at_limit;
   logic fire, clear;

   wv_verdict #(.CODE_W(CODE_W)) u_verdict (
      .reading (rd_code),
      .goal    (tgt_q),
      .dir     (dir_q),
      .same    (same),
      .below   (below),
      .reached (reached)
   );

   wv_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (fire),
      .active (tmr_active),
      .last   (tmr_last)
   );

   wv_pulse_tally #(
      .SET_LIMIT   (SET_LIMIT),
      .RESET_LIMIT (RESET_LIMIT),
      .CNT_W       (CNT_W)
   ) u_tally (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .bump     (fire),
      .dir      (dir_q),
      .count    (pulse_cnt),
      .at_limit (at_limit)
   );

   assign clear = (state == ST_IDLE) && start;
   assign fire  = (state == ST_READ) && rd_valid &&
                  (first_q ? !same : (!reached && !at_limit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         dir_q   <= DIR_UP;
         tgt_q   <= '0;
         first_q <= 1'b0;
         pass_q  <= 1'b0;
         final_q <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  tgt_q   <= target;
                  first_q <= 1'b1;
                  pass_q  <= 1'b0;
                  state   <= ST_READ;
               end
            end
            ST_READ: begin
               if (rd_valid) begin
                  final_q <= rd_code;
                  first_q <= 1'b0;
                  if (first_q) begin
                     if (same) begin
                        pass_q <= 1'b1;
                        state  <= ST_DONE;
                     end else begin
                        dir_q <= below ? DIR_UP : DIR_DOWN;
                        state <= ST_PULSE;
                     end
                  end else if (reached) begin
                     pass_q <= 1'b1;
                     state  <= ST_DONE;
                  end else if (at_limit) begin
                     state <= ST_DONE;
                  end else begin
                     state <= ST_PULSE;
                  end
               end
            end
            ST_PULSE: begin
               if (tmr_last) state <= ST_READ;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign set_pulse   = tmr_active && (dir_q == DIR_UP);
   assign reset_pulse = tmr_active && (dir_q == DIR_DOWN);
   assign rd_req      = (state == ST_READ);
   assign done        = (state == ST_DONE);
   assign pass        = pass_q;
   assign final_code  = final_q;

   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_pulse && reset_pulse)); // R11
   AST_DONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11
   AST_NO_READ_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_active |-> !rd_req); // R5
   AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_active && !fire |=> $stable(dir_q)); // R8
   AST_TGT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      state != ST_IDLE |=> $stable(tgt_q)); // R10
   AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      done && !pass |-> pulse_cnt == ((dir_q == DIR_UP) ? CNT_W'(SET_LIMIT)
                                                        : CNT_W'(RESET_LIMIT))); // R6
   AST_PASS_MET: assert property (@(posedge clk) disable iff (!rst_n)
      done && pass && pulse_cnt != '0 |->
         ((dir_q == DIR_UP) ? (final_code >= tgt_q) : (final_code <= tgt_q))); // R3

endmodule

// File: tb/wv_prog_ctrl_bench.sv
`timescale 1ns/1ps
module wv_prog_ctrl_bench;

   localparam int CW    = 4;
   localparam int PW    = 3;
   localparam int SL    = 5;
   localparam int RL    = 7;
   localparam int NW    = $clog2(((SL > RL) ? SL : RL) + 1);
   localparam int TOP   = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] target = '0;
   logic [CW-1:0] rd_code = '0;
   logic          rd_valid = 1'b0;
   logic          set_pulse, reset_pulse, rd_req, done, pass;
   logic [NW-1:0] pulse_cnt;
   logic [CW-1:0] final_code;

   wv_prog_ctrl #(
      .CODE_W(CW), .PULSE_CYC(PW), .SET_LIMIT(SL), .RESET_LIMIT(RL)
   ) u_wv_prog_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .target(target),
      .rd_code(rd_code), .rd_valid(rd_valid), .set_pulse(set_pulse),
      .reset_pulse(reset_pulse), .rd_req(rd_req), .done(done), .pass(pass),
      .pulse_cnt(pulse_cnt), .final_code(final_code)
   );

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit finished = 0;

   // cell model state
   int  g = 0;
   int  step = 0;
   int  lat_cfg = 0;
   int  lat = 0;
   bit  pend = 0;
   bit  need_read = 0;
   bit  prev_p = 0;
   int  plen = 0;
   int  n_up = 0;
   int  n_dn = 0;
   bit  meddle = 0;
   bit  meddled = 0;
   bit  clr_start = 0;
   int  cur_t = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   initial forever #4 clk = ~clk;

   initial forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // cell and sense-path model
   initial forever begin
      @(negedge clk);
      if (clr_start) begin start = 1'b0; clr_start = 0; end
      if (set_pulse || reset_pulse) begin
         if (!prev_p) begin
            chk(need_read == 0, "R5", need_read, 0);
            if (set_pulse) begin g = (g + step > TOP) ? TOP : g + step; n_up++; end
            else           begin g = (g - step < 0) ? 0 : g - step;    n_dn++; end
            plen = 1;
            if (meddle && !meddled) begin
               meddled = 1;
               start = 1'b1;
               target = ~cur_t[CW-1:0];
               clr_start = 1;
            end
         end else plen++;
         prev_p = 1;
      end else begin
         if (prev_p) begin
            chk(plen == PW, "R5", plen, PW);
            need_read = 1;
         end
         prev_p = 0;
      end
      if (rd_valid) rd_valid = 1'b0;
      else if (rd_req) begin
         if (!pend) begin pend = 1; lat = lat_cfg; end
         if (lat == 0) begin
            rd_valid = 1'b1;
            rd_code = g[CW-1:0];
            pend = 0;
            need_read = 0;
         end else lat--;
      end
   end

   task automatic run(input int g0, input int t, input int s);
      int  n, exp_cnt, exp_fin, wait_c;
      bit  exp_pass;
      string tag;
      g = g0; step = s; lat_cfg = (g0 * 2 + t) % 3;
      n_up = 0; n_dn = 0; meddled = 0; need_read = 0;
      meddle = ((g0 + t) % 4 == 0) && (g0 != t);
      cur_t = t;
      if (g0 == t) begin
         exp_pass = 1; exp_cnt = 0; exp_fin = g0; tag = "R2";
      end else if (g0 < t) begin
         n = (s == 0) ? SL + 1 : (t - g0 + s - 1) / s;
         if (n <= SL) begin
            exp_pass = 1; exp_cnt = n;
            exp_fin = (g0 + n * s > TOP) ? TOP : g0 + n * s;
            tag = (exp_fin != t) ? "R8" : "R3";
         end else begin
            exp_pass = 0; exp_cnt = SL; exp_fin = g0 + SL * s; tag = "R6";
         end
      end else begin
         n = (s == 0) ? RL + 1 : (g0 - t + s - 1) / s;
         if (n <= RL) begin
            exp_pass = 1; exp_cnt = n;
            exp_fin = (g0 - n * s < 0) ? 0 : g0 - n * s;
            tag = (exp_fin != t) ? "R8" : "R4";
         end else begin
            exp_pass = 0; exp_cnt = RL; exp_fin = g0 - RL * s; tag = "R7";
         end
      end
      @(negedge clk);
      target = t[CW-1:0];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_c = 0;
      while (!done && wait_c < 2000) begin
         @(negedge clk);
         wait_c++;
      end
      chk(done == 1'b1, tag, done, 1);
      chk(pass == exp_pass, meddle ? "R10" : tag, pass, exp_pass);
      chk(int'(pulse_cnt) == exp_cnt, meddle ? "R10" : tag, pulse_cnt, exp_cnt);
      chk(int'(final_code) == exp_fin, "R9", final_code, exp_fin);
      chk(n_up + n_dn == exp_cnt, "R9", n_up + n_dn, exp_cnt);
      if (g0 < t) chk(n_dn == 0, "R3", n_dn, 0);
      else        chk(n_up == 0, "R4", n_up, 0);
      @(negedge clk);
      chk(done == 1'b0, "R11", done, 0);
      chk(int'(pulse_cnt) == exp_cnt && pass == exp_pass, "R9", pulse_cnt, exp_cnt);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!set_pulse && !reset_pulse && !rd_req && !done, "R1", {set_pulse, reset_pulse, rd_req, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!pass && pulse_cnt == '0 && !done && !rd_req, "R1", pulse_cnt, 0);
      for (int s = 0; s < 3; s++) begin
         for (int g0 = 0; g0 <= TOP; g0++) begin
            for (int t = 0; t <= TOP; t++) begin
               run(g0, t, (s == 2) ? 3 : s);
            end
         end
      end
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule